// File: doc/BRIEF.md
# Paired Load/Store Address Sequencer

This block carries out one two-element memory transfer per command. A command supplies a base address, a small signed immediate, an element size (32-bit word or 64-bit doubleword), an indexing mode, a direction and, for word loads, a sign-extension choice. Stores also supply two data operands. The block scales the immediate by the element size and forms the first element address. The second element sits directly above the first. It then drives two beats, lower address first, on a byte-addressed memory port that uses a valid/ready handshake.

When the second beat completes, the block pulses its outputs for one cycle. A load returns both elements, widened to 64 bits. A pre-indexed or post-indexed command returns the updated base together with a writeback strobe. While a transfer is in flight a busy output is high, and any command offered during that time is dropped. The block has no alignment checks, and all address sums wrap modulo 2^ADDR_W.

Top module: `pair_xfer_seq`

## Requirements
- R1: The 7-bit immediate `cmd_imm` is read as two's complement and multiplied by the element size before it is added to the base. The size is 4 for words (`cmd_dword`=0) and 8 for doublewords (`cmd_dword`=1).
- R2: For `cmd_mode` 0 (plain offset) and the spare code 3, the first address is base plus scaled offset, and `wb_valid` stays low.
- R3: For `cmd_mode` 1 (pre-index), the first address is base plus scaled offset, and that same sum is presented on `wb_base` with `wb_valid` high.
- R4: For `cmd_mode` 2 (post-index), the first address is the unmodified base, and base plus scaled offset is presented on `wb_base`. This holds even when the offset is zero, in which case `wb_valid` is still high and the returned base is unchanged.
- R5: The second beat address equals the first plus 4 (word) or plus 8 (doubleword). All sums wrap modulo 2^64, and any byte alignment is accepted.
- R6: A store puts `cmd_wdata0` on the lower address and `cmd_wdata1` on the higher one. On word stores, only bits [31:0] are driven, and the upper half of `mem_wdata` is zero. `mem_write` is high on both beats of a store and low on both beats of a load.
- R7: A load returns the element read from the lower address on `res_data0` and the one from the higher address on `res_data1`. Doubleword loads return the full 64-bit `mem_rdata`.
- R8: A word load with `cmd_sext`=1 returns each element as `mem_rdata[31:0]` sign-extended to 64 bits.
- R9: A word load with `cmd_sext`=0 returns each element as `mem_rdata[31:0]` zero-extended. Upper read bits are ignored.
- R10: Exactly two beats are issued per command, lower address first. While `mem_valid` is high and `mem_ready` is low, the address, write flag, size and write data do not change.
- R11: `busy` is high from the cycle after a command is taken until the results are presented. A `cmd_valid` seen while `busy` is high starts no transfer.
- R12: `res_valid` (loads only) and `wb_valid` pulse for exactly one cycle, together, on the cycle after the second beat's handshake. After that pulse, `busy` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; taken when busy is low |
| cmd_base | input | 64 | Base address |
| cmd_imm | input | 7 | Signed immediate, in element units |
| cmd_dword | input | 1 | 1 = doubleword pair, 0 = word pair |
| cmd_mode | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 offset |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_sext | input | 1 | Sign-extend word loads |
| cmd_wdata0 | input | 64 | Store data for lower address |
| cmd_wdata1 | input | 64 | Store data for higher address |
| busy | output | 1 | Transfer in flight |
| mem_valid | output | 1 | Beat request |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_write | output | 1 | Beat is a write |
| mem_dword | output | 1 | Beat size: 1 = 8 bytes, 0 = 4 bytes |
| mem_addr | output | 64 | Byte address of beat |
| mem_wdata | output | 64 | Write data of beat |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| res_valid | output | 1 | Load results valid (one cycle) |
| res_data0 | output | 64 | Element from lower address |
| res_data1 | output | 64 | Element from higher address |
| wb_valid | output | 1 | Updated base valid (one cycle) |
| wb_base | output | 64 | Updated base value |

## Verification
The bench drives the immediate to its extremes (-64 and +63) at both sizes. A design that scales before sign extension, or that uses the wrong shift, lands on wrong addresses there. It places a base near the top of the address space, so that a design which saturates or mis-carries the second-beat address is caught. It uses a post-index command with zero offset, where a design that gates writeback on a non-zero offset would drop the strobe. Word loads return negative values with junk in the upper read bits, which exposes a swapped sign/zero extension or a missing mask. Random ready stalls and commands offered while busy catch a design that moves its address during a stall or that starts a third beat.

// File: rtl/pair_xfer_pkg.sv
package pair_xfer_pkg;

   typedef enum logic [1:0] {
      AM_OFFSET = 2'd0,
      AM_PRE    = 2'd1,
      AM_POST   = 2'd2,
      AM_SPARE  = 2'd3
   } addr_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LO   = 2'd1,
      SQ_HI   = 2'd2,
      SQ_DONE = 2'd3
   } seq_state_e;

   localparam int unsigned WORD_BYTES_LOG2  = 2;
   localparam int unsigned DWORD_BYTES_LOG2 = 3;

endpackage

// File: rtl/pair_addr_calc.sv
module pair_addr_calc
   import pair_xfer_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned IMM_W  = 7
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   input  logic              dword,
   input  logic [1:0]        mode,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] wb_value,
   output logic              wb_en
);

   localparam int unsigned EXT_W = ADDR_W - IMM_W;

   if (IMM_W < 2) begin : g_bad_imm
      $error("pair_addr_calc: IMM_W must be at least 2");
   end
   if (ADDR_W < IMM_W + DWORD_BYTES_LOG2 + 1) begin : g_bad_addr
      $error("pair_addr_calc: ADDR_W too small for scaled immediate");
   end

   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] scaled;
   logic [ADDR_W-1:0] offset_sum;
   addr_mode_e        am;

   always_comb begin
      am         = addr_mode_e'(mode);
      imm_ext    = {{EXT_W{imm[IMM_W-1]}}, imm};
      scaled     = dword ? (imm_ext << DWORD_BYTES_LOG2) : (imm_ext << WORD_BYTES_LOG2);
      offset_sum = base + scaled;
      first_addr = (am == AM_POST) ? base : offset_sum;
      wb_value   = offset_sum;
      wb_en      = (am == AM_PRE) || (am == AM_POST);
   end

endmodule

// File: rtl/pair_load_shape.sv
module pair_load_shape #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned LANES   = 2,
   parameter bit          SEXT_EN = 1'b1
) (
   input  logic [LANES-1:0][DATA_W-1:0] raw,
   input  logic                         dword,
   input  logic                         sext,
   output logic [LANES-1:0][DATA_W-1:0] shaped
);

   localparam int unsigned HALF_W = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("pair_load_shape: DATA_W must be even");
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic fill;
      if (SEXT_EN) begin : g_sext
         assign fill = sext & raw[ln][HALF_W-1];
      end else begin : g_zext
         assign fill = 1'b0;
      end
      assign shaped[ln] = dword ? raw[ln] : {{HALF_W{fill}}, raw[ln][HALF_W-1:0]};
   end

endmodule

// File: rtl/pair_beat_fsm.sv
module pair_beat_fsm
   import pair_xfer_pkg::*;
#(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] first_addr,
   input  logic              dword_in,
   input  logic              store_in,
   input  logic [DATA_W-1:0] wdata0_in,
   input  logic [DATA_W-1:0] wdata1_in,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              mem_valid,
   output logic              mem_write,
   output logic              mem_dword,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] raw0,
   output logic [DATA_W-1:0] raw1,
   output logic              done,
   output logic              is_store
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(1) << WORD_BYTES_LOG2;
   localparam logic [ADDR_W-1:0] STEP_D = ADDR_W'(1) << DWORD_BYTES_LOG2;

   seq_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic              dword_q;
   logic              store_q;
   logic [DATA_W-1:0] wd0_q, wd1_q;
   logic [DATA_W-1:0] wd_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         addr_q  <= '0;
         dword_q <= 1'b0;
         store_q <= 1'b0;
         wd0_q   <= '0;
         wd1_q   <= '0;
         raw0    <= '0;
         raw1    <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (start) begin
               addr_q  <= first_addr;
               dword_q <= dword_in;
               store_q <= store_in;
               wd0_q   <= wdata0_in;
               wd1_q   <= wdata1_in;
               state   <= SQ_LO;
            end
            SQ_LO: if (mem_ready) begin
               raw0   <= mem_rdata;
               addr_q <= addr_q + (dword_q ? STEP_D : STEP_W);
               state  <= SQ_HI;
            end
            SQ_HI: if (mem_ready) begin
               raw1  <= mem_rdata;
               state <= SQ_DONE;
            end
            SQ_DONE: state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (state != SQ_IDLE);
      mem_valid = (state == SQ_LO) || (state == SQ_HI);
      mem_write = store_q;
      mem_dword = dword_q;
      mem_addr  = addr_q;
      wd_sel    = (state == SQ_HI) ? wd1_q : wd0_q;
      mem_wdata = dword_q ? wd_sel : {{HALF_W{1'b0}}, wd_sel[HALF_W-1:0]};
      done      = (state == SQ_DONE);
      is_store  = store_q;
   end

   // R10
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)
                                     && $stable(mem_write) && $stable(mem_dword)));

   // R5
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_LO && mem_ready) |=>
         (mem_addr == $past(mem_addr) + ($past(mem_dword) ? STEP_D : STEP_W)));

   // R12
   done_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_HI && mem_ready) |=> (done && !mem_valid));

endmodule

// File: rtl/pair_xfer_seq.sv
module pair_xfer_seq #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned IMM_W   = 7,
   parameter bit          SEXT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [IMM_W-1:0]  cmd_imm,
   input  logic              cmd_dword,
   input  logic [1:0]        cmd_mode,
   input  logic              cmd_store,
   input  logic              cmd_sext,
   input  logic [DATA_W-1:0] cmd_wdata0,
   input  logic [DATA_W-1:0] cmd_wdata1,
   output logic              busy,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic              mem_dword,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data0,
   output logic [DATA_W-1:0] res_data1,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_base
);

   localparam int unsigned LANES  = 2;
   localparam int unsigned HALF_W = DATA_W / 2;

   if (DATA_W != 64) begin : g_bad_data
      $error("pair_xfer_seq: DATA_W must be 64 for word/doubleword pairs");
   end

   logic              start;
   logic [ADDR_W-1:0] first_addr, wb_value;
   logic              wb_en;
   logic              wb_en_q, sext_q;
   logic [ADDR_W-1:0] wb_base_q;
   logic [DATA_W-1:0] raw0, raw1;
   logic              done, is_store;
   logic [LANES-1:0][DATA_W-1:0] raw_pair, shaped_pair;

   assign start = cmd_valid && !busy;

   pair_addr_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_calc (
      .base       (cmd_base),
      .imm        (cmd_imm),
      .dword      (cmd_dword),
      .mode       (cmd_mode),
      .first_addr (first_addr),
      .wb_value   (wb_value),
      .wb_en      (wb_en)
   );

   pair_beat_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .first_addr (first_addr),
      .dword_in   (cmd_dword),
      .store_in   (cmd_store),
      .wdata0_in  (cmd_wdata0),
      .wdata1_in  (cmd_wdata1),
      .mem_ready  (mem_ready),
      .mem_rdata  (mem_rdata),
      .busy       (busy),
      .mem_valid  (mem_valid),
      .mem_write  (mem_write),
      .mem_dword  (mem_dword),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .raw0       (raw0),
      .raw1       (raw1),
      .done       (done),
      .is_store   (is_store)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_en_q   <= 1'b0;
         sext_q    <= 1'b0;
         wb_base_q <= '0;
      end else if (start) begin
         wb_en_q   <= wb_en;
         sext_q    <= cmd_sext;
         wb_base_q <= wb_value;
      end
   end

   assign raw_pair[0] = raw0;
   assign raw_pair[1] = raw1;

   pair_load_shape #(.DATA_W(DATA_W), .LANES(LANES), .SEXT_EN(SEXT_EN)) u_shape (
      .raw    (raw_pair),
      .dword  (mem_dword),
      .sext   (sext_q),
      .shaped (shaped_pair)
   );

   assign res_valid = done && !is_store;
   assign res_data0 = shaped_pair[0];
   assign res_data1 = shaped_pair[1];
   assign wb_valid  = done && wb_en_q;
   assign wb_base   = wb_base_q;

   // R8
   sext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !mem_dword && sext_q) |->
         (res_data0[DATA_W-1:HALF_W] == {HALF_W{res_data0[HALF_W-1]}} &&
          res_data1[DATA_W-1:HALF_W] == {HALF_W{res_data1[HALF_W-1]}}));

   // R12
   busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid || wb_valid) |=> (!busy && !res_valid && !wb_valid));

   // R11
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   // R10
   valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> busy);

endmodule

// File: tb/pair_xfer_seq_test.sv
module pair_xfer_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [63:0] cmd_base = '0;
   logic [6:0]  cmd_imm = '0;
   logic        cmd_dword = 1'b0;
   logic [1:0]  cmd_mode = '0;
   logic        cmd_store = 1'b0;
   logic        cmd_sext = 1'b0;
   logic [63:0] cmd_wdata0 = '0, cmd_wdata1 = '0;
   logic        busy, mem_valid, mem_write, mem_dword;
   logic        mem_ready = 1'b0;
   logic [63:0] mem_addr, mem_wdata, mem_rdata;
   logic        res_valid, wb_valid;
   logic [63:0] res_data0, res_data1, wb_base;

   always #4 clk = ~clk;

   pair_xfer_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
      .cmd_imm(cmd_imm), .cmd_dword(cmd_dword), .cmd_mode(cmd_mode),
      .cmd_store(cmd_store), .cmd_sext(cmd_sext), .cmd_wdata0(cmd_wdata0),
      .cmd_wdata1(cmd_wdata1), .busy(busy), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_write(mem_write), .mem_dword(mem_dword),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .res_valid(res_valid), .res_data0(res_data0), .res_data1(res_data1),
      .wb_valid(wb_valid), .wb_base(wb_base)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit stall_en = 1'b1;

   function automatic logic [63:0] mem_img(input logic [63:0] a);
      logic [31:0] lo, hi;
      lo = (a[31:0] * 32'h9E37_79B9) ^ 32'h5A5A_0F0F ^ a[63:32];
      hi = ~a[31:0] + a[63:32] + 32'h0123_4567;
      return {hi, lo};
   endfunction

   assign mem_rdata = mem_img(mem_addr);

   int          nbeat;
   logic [63:0] b_addr [2];
   logic [63:0] b_wd   [2];
   logic        b_we   [2];
   logic        b_dw   [2];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && mem_valid && mem_ready) begin
         if (nbeat < 2) begin
            b_addr[nbeat] = mem_addr;
            b_wd[nbeat]   = mem_wdata;
            b_we[nbeat]   = mem_write;
            b_dw[nbeat]   = mem_dword;
         end
         nbeat = nbeat + 1;
      end
   end

   always @(negedge clk) begin
      mem_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] shape(input logic [63:0] r, input bit dw, input bit sx);
      if (dw) return r;
      if (sx) return {{32{r[31]}}, r[31:0]};
      return {32'h0, r[31:0]};
   endfunction

   task automatic run_cmd(input logic [63:0] base, input logic [6:0] imm, input bit dw,
                          input logic [1:0] mode, input bit st, input bit sx,
                          input logic [63:0] d0, input logic [63:0] d1, input bit poke);
      logic [63:0] scaled, sum, a0, a1, e0, e1;
      bit exp_wb;
      int res_n, wb_n, res_c, wb_c, guard;
      logic [63:0] r0, r1, wbv;
      scaled = dw ? ({{57{imm[6]}}, imm} << 3) : ({{57{imm[6]}}, imm} << 2);
      sum    = base + scaled;
      a0     = (mode == 2'd2) ? base : sum;
      a1     = a0 + (dw ? 64'd8 : 64'd4);
      exp_wb = (mode == 2'd1) || (mode == 2'd2);
      res_n = 0; wb_n = 0; res_c = 0; wb_c = -1; r0 = '0; r1 = '0; wbv = '0;
      @(negedge clk);
      nbeat = 0;
      cmd_base = base; cmd_imm = imm; cmd_dword = dw; cmd_mode = mode;
      cmd_store = st; cmd_sext = sx; cmd_wdata0 = d0; cmd_wdata1 = d1;
      cmd_valid = 1'b1;
      @(negedge clk);
      if (poke) begin
         cmd_base = ~base; cmd_imm = imm + 7'd5; cmd_mode = 2'd1;
         cmd_store = ~st; cmd_dword = ~dw;
      end else begin
         cmd_valid = 1'b0;
      end
      guard = 0;
      do begin
         if (res_valid) begin res_n++; res_c = cyc; r0 = res_data0; r1 = res_data1; end
         if (wb_valid)  begin wb_n++;  wb_c = cyc;  wbv = wb_base; end
         if (busy) @(negedge clk);
         guard++;
      end while (busy && guard < 1000);
      cmd_valid = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         chk(nbeat == 2, "R11 no extra beats from command offered while busy", 64'(nbeat), 64'd2);
      end
      chk(nbeat == 2, "R10 beat count", 64'(nbeat), 64'd2);
      chk(b_addr[0] == a0, "R1/R2/R3/R4 first address", b_addr[0], a0);
      chk(b_addr[1] == a1, "R5 second address", b_addr[1], a1);
      chk(b_we[0] == st && b_we[1] == st, "R6 write flag", {b_we[0], b_we[1]}, {st, st});
      chk(b_dw[0] == dw && b_dw[1] == dw, "R10 beat size", {b_dw[0], b_dw[1]}, {dw, dw});
      if (st) begin
         e0 = dw ? d0 : {32'h0, d0[31:0]};
         e1 = dw ? d1 : {32'h0, d1[31:0]};
         chk(b_wd[0] == e0, "R6 lower store data", b_wd[0], e0);
         chk(b_wd[1] == e1, "R6 upper store data", b_wd[1], e1);
         chk(res_n == 0, "R12 no load result on store", 64'(res_n), 64'd0);
      end else begin
         e0 = shape(mem_img(a0), dw, sx);
         e1 = shape(mem_img(a1), dw, sx);
         chk(res_n == 1, "R12 one result pulse", 64'(res_n), 64'd1);
         chk(r0 == e0, dw ? "R7 first element" : (sx ? "R8 first element" : "R9 first element"), r0, e0);
         chk(r1 == e1, dw ? "R7 second element" : (sx ? "R8 second element" : "R9 second element"), r1, e1);
         if (exp_wb) chk(wb_c == res_c, "R12 writeback same cycle as results", 64'(wb_c), 64'(res_c));
      end
      chk(wb_n == (exp_wb ? 1 : 0), exp_wb ? "R3/R4 writeback strobe" : "R2 no writeback", 64'(wb_n), 64'(exp_wb));
      if (exp_wb) chk(wbv == sum, "R4/R3 written-back base", wbv, sum);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(!busy && !mem_valid && !res_valid && !wb_valid, "R11 reset state idle",
          {busy, mem_valid, res_valid, wb_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_valid, "R12 idle after reset", {busy, mem_valid}, 64'd0);
      // R1 extremes of the immediate, both sizes
      run_cmd(64'h1000, 7'h40, 1'b1, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0);
      run_cmd(64'h1000, 7'h3F, 1'b0, 2'd1, 1'b0, 1'b0, '0, '0, 1'b0);
      run_cmd(64'h2000, 7'h40, 1'b0, 2'd2, 1'b1, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 1'b0);
      // R5 wrap at top of address space, unaligned
      run_cmd(64'hFFFF_FFFF_FFFF_FFFB, 7'h00, 1'b1, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0);
      run_cmd(64'hFFFF_FFFF_FFFF_FFF3, 7'h01, 1'b1, 2'd1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0);
      // R4 post-index with zero offset
      run_cmd(64'h0000_0000_0000_5557, 7'h00, 1'b0, 2'd2, 1'b0, 1'b1, '0, '0, 1'b0);
      // R2 spare mode behaves as offset
      run_cmd(64'h3001, 7'h7F, 1'b0, 2'd3, 1'b0, 1'b0, '0, '0, 1'b0);
      // R11 command held during busy is ignored
      stall_en = 1'b0;
      run_cmd(64'h4000, 7'h02, 1'b1, 2'd0, 1'b0, 1'b0, '0, '0, 1'b1);
      stall_en = 1'b1;
      run_cmd(64'h4800, 7'h7E, 1'b0, 2'd1, 1'b1, 1'b0, 64'hDEAD_BEEF_8000_0001, 64'hCAFE_F00D_7FFF_FFFF, 1'b1);
      // random mix, R8 and R9 covered by word loads
      for (int i = 0; i < 300; i++) begin
         run_cmd({$urandom, $urandom}, 7'($urandom), 1'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, (i % 37) == 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule